// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of a single DMA channel. It keeps a source address, a destination address and a unit counter. For each transfer unit it moves data with a read bus cycle at the source followed by a write bus cycle at the destination, using a plain request/acknowledge handshake. Once a unit is finished the counter drops by one and each address moves by the unit size in the direction its mode selects. When the counter reaches zero the channel flags a normal end and, if enabled, raises an interrupt request.

A transfer needs a request. In self-request mode the channel makes its own requests. In the other mode a rising edge on an external request line is captured and held until the unit it started begins. In cycle-steal operation the channel drops its bus request after every unit and waits for a new request. In burst operation it runs the remaining units back to back. An abort stops the channel before its next unit without a normal end. The causes are a non-maskable-interrupt event, an address-error event, or a drop of either enable. A 16-byte unit is carried out as four longword read/write pairs, and all four always finish before an abort takes effect.

Top module: `dma_chan_seq`

## Requirements
- R1: No unit starts unless `ch_en` and `master_en` are both 1 and the end, NMI and address-error flags are all 0.
- R2: With `auto_req`=1 a unit starts with no external request once the R1 condition holds.
- R3: Each beat is a read with `bus_wr`=0 at the source, then a write with `bus_wr`=1 at the destination. Each request holds its address and direction until `bus_ack` is sampled high.
- R4: After each unit, `count` decrements by one and each address is updated by its 2-bit mode: 00 fixed, 01 add step, 10 subtract step, 11 fixed. The step comes from `xfer_size`: 00→1, 01→2, 10→4, 11→16 bytes.
- R5: The unit that brings `count` to zero sets `end_flag`, and only such a unit does. `end_irq` is high while `end_flag` and `int_en` are both 1.
- R6: A loaded count of 0 runs 2^CW units.
- R7: A pulse on `nmi_evt` or `addr_err_evt` sets the matching sticky flag. That flag, or a 0 on either enable, stops the channel after the current unit, with `end_flag` left 0.
- R8: A unit with `xfer_size`=11 runs four read/write beats at base+0, +4, +8 and +12, and all four complete even if an abort arises during the block.
- R9: With `burst_mode`=0, `bus_req` is low for at least one cycle between units. With an external request, each unit needs a fresh rising edge of `dreq`.
- R10: With `burst_mode`=1, units follow each other with `bus_req` held high, and one captured edge of `dreq` runs the whole count.
- R11: A rising edge of `dreq` is held pending while the channel cannot start, and a `dreq` held high yields one request only.
- R12: `cfg_load` while idle loads the addresses and count and clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load addresses and count, clear flags (idle only) |
| cfg_src | input | AW | Source address to load |
| cfg_dst | input | AW | Destination address to load |
| cfg_count | input | CW | Unit count to load (0 means 2^CW) |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| xfer_size | input | 2 | Unit size code |
| auto_req | input | 1 | 1: self-request, 0: external edge request |
| burst_mode | input | 1 | 1: burst, 0: cycle-steal |
| dreq | input | 1 | External request line |
| ch_en | input | 1 | Channel enable |
| master_en | input | 1 | Master enable |
| int_en | input | 1 | End interrupt enable |
| nmi_evt | input | 1 | Non-maskable interrupt event pulse |
| addr_err_evt | input | 1 | Address error event pulse |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | 1 write cycle, 0 read cycle |
| bus_addr | output | AW | Bus cycle address |
| bus_ack | input | 1 | Bus cycle acknowledge |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| count | output | CW | Remaining unit count |
| end_flag | output | 1 | Normal end flag |
| nmi_flag | output | 1 | Sticky NMI flag |
| addr_err_flag | output | 1 | Sticky address-error flag |
| end_irq | output | 1 | End interrupt request |
| busy | output | 1 | Channel is in a bus sequence |

## Verification
The hardest case to reach is an abort that lands inside a 16-byte block. The event has to arrive after the first beat is acknowledged and before the fourth write completes. The bench's bus responder stretches every acknowledge by several cycles and logs each beat. The stimulus waits for the first logged beat and then pulses the error event, so the abort always falls inside the block. The same log, which records for each beat whether `bus_req` dropped before it, checks the cycle-steal and burst spacing across a full sweep of address modes and unit sizes.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam logic [1:0] AM_FIXED = 2'b00;
  localparam logic [1:0] AM_INC   = 2'b01;
  localparam logic [1:0] AM_DEC   = 2'b10;

  localparam logic [1:0] SZ_1  = 2'b00;
  localparam logic [1:0] SZ_2  = 2'b01;
  localparam logic [1:0] SZ_4  = 2'b10;
  localparam logic [1:0] SZ_16 = 2'b11;

  localparam int BLK_BEATS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  // Bytes moved by one unit for a size code.
  function automatic logic [4:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      SZ_1:    return 5'd1;
      SZ_2:    return 5'd2;
      SZ_4:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // Byte offset of a beat inside a 16-byte block.
  function automatic logic [3:0] beat_offset(input logic [1:0] sz, input logic [1:0] beat);
    return (sz == SZ_16) ? {beat, 2'b00} : 4'd0;
  endfunction

endpackage

// File: rtl/dma_req_edge.sv
module dma_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic consume,
  output logic pending
);
  logic dreq_q;
  logic rise;

  assign rise = dreq && !dreq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      dreq_q  <= dreq;
      pending <= (pending && !consume) || rise;
    end
  end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [1:0]    xfer_size,
  input  logic          unit_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic          last_unit
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a,
                                              input logic [1:0] mode,
                                              input logic [1:0] sz);
    logic [AW-1:0] step;
    step = {{(AW-5){1'b0}}, unit_bytes(sz)};
    case (mode)
      AM_INC:  return a + step;
      AM_DEC:  return a - step;
      default: return a;
    endcase
  endfunction

  assign last_unit = (count == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
      count    <= '0;
    end else if (load_en) begin
      src_addr <= cfg_src;
      dst_addr <= cfg_dst;
      count    <= cfg_count;
    end else if (unit_done) begin
      src_addr <= next_addr(src_addr, src_mode, xfer_size);
      dst_addr <= next_addr(dst_addr, dst_mode, xfer_size);
      count    <= count - CNT_ONE;
    end
  end
endmodule

// File: rtl/dma_status_flags.sv
module dma_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic unit_done,
  input  logic last_unit,
  input  logic nmi_evt,
  input  logic addr_err_evt,
  output logic end_flag,
  output logic nmi_flag,
  output logic addr_err_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_flag      <= 1'b0;
      nmi_flag      <= 1'b0;
      addr_err_flag <= 1'b0;
    end else begin
      if (load_en)                     end_flag <= 1'b0;
      else if (unit_done && last_unit) end_flag <= 1'b1;

      if (nmi_evt)      nmi_flag <= 1'b1;
      else if (load_en) nmi_flag <= 1'b0;

      if (addr_err_evt) addr_err_flag <= 1'b1;
      else if (load_en) addr_err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_ok,
  input  logic       req,
  input  logic       burst,
  input  logic [1:0] xfer_size,
  input  logic       last_unit,
  input  logic       bus_ack,
  output logic       bus_req,
  output logic       bus_wr,
  output logic [1:0] beat,
  output logic       start_evt,
  output logic       unit_done,
  output logic       blk_step,
  output logic       idle
);
  seq_state_e st, st_nx;
  logic [1:0] beat_nx;
  logic       unit_end;

  assign unit_end = (xfer_size != SZ_16) || (beat == 2'(BLK_BEATS - 1));
  assign bus_req  = (st == ST_RD) || (st == ST_WR);
  assign bus_wr   = (st == ST_WR);
  assign idle     = (st == ST_IDLE);

  always_comb begin
    st_nx     = st;
    beat_nx   = beat;
    start_evt = 1'b0;
    unit_done = 1'b0;
    blk_step  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (go_ok && req) begin
          start_evt = 1'b1;
          st_nx     = ST_RD;
          beat_nx   = 2'd0;
        end
      end
      ST_RD: begin
        if (bus_ack) st_nx = ST_WR;
      end
      ST_WR: begin
        if (bus_ack) begin
          if (!unit_end) begin
            blk_step = 1'b1;
            st_nx    = ST_RD;
            beat_nx  = beat + 2'd1;
          end else begin
            unit_done = 1'b1;
            beat_nx   = 2'd0;
            st_nx     = (last_unit || !go_ok || !burst) ? ST_IDLE : ST_RD;
          end
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      beat <= 2'd0;
    end else begin
      st   <= st_nx;
      beat <= beat_nx;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [1:0]    xfer_size,
  input  logic          auto_req,
  input  logic          burst_mode,
  input  logic          dreq,
  input  logic          ch_en,
  input  logic          master_en,
  input  logic          int_en,
  input  logic          nmi_evt,
  input  logic          addr_err_evt,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_ack,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] count,
  output logic          end_flag,
  output logic          nmi_flag,
  output logic          addr_err_flag,
  output logic          end_irq,
  output logic          busy
);
  // Named internal events, also observed by the bound checker.
  logic       go_ok;
  logic       pending;
  logic       start_evt;
  logic       unit_done;
  logic       blk_step;
  logic       idle;
  logic       last_unit;
  logic       load_en;
  logic [1:0] beat;
  logic [AW-1:0] base;

  assign go_ok = ch_en && master_en && !end_flag
              && !nmi_flag && !nmi_evt
              && !addr_err_flag && !addr_err_evt;
  assign load_en = cfg_load && idle;

  dma_req_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .dreq    (dreq),
    .consume (start_evt && !auto_req),
    .pending (pending)
  );

  dma_addr_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .cfg_src   (cfg_src),
    .cfg_dst   (cfg_dst),
    .cfg_count (cfg_count),
    .src_mode  (src_mode),
    .dst_mode  (dst_mode),
    .xfer_size (xfer_size),
    .unit_done (unit_done),
    .src_addr  (src_addr),
    .dst_addr  (dst_addr),
    .count     (count),
    .last_unit (last_unit)
  );

  dma_status_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_en       (load_en),
    .unit_done     (unit_done),
    .last_unit     (last_unit),
    .nmi_evt       (nmi_evt),
    .addr_err_evt  (addr_err_evt),
    .end_flag      (end_flag),
    .nmi_flag      (nmi_flag),
    .addr_err_flag (addr_err_flag)
  );

  dma_bus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_ok     (go_ok),
    .req       (auto_req || pending),
    .burst     (burst_mode),
    .xfer_size (xfer_size),
    .last_unit (last_unit),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .beat      (beat),
    .start_evt (start_evt),
    .unit_done (unit_done),
    .blk_step  (blk_step),
    .idle      (idle)
  );

  assign base     = bus_wr ? dst_addr : src_addr;
  assign bus_addr = base + {{(AW-4){1'b0}}, beat_offset(xfer_size, beat)};
  assign end_irq  = end_flag && int_en;
  assign busy     = !idle;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_wr,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [CW-1:0] count,
  input logic          end_flag,
  input logic          nmi_flag,
  input logic          addr_err_flag,
  input logic          ch_en,
  input logic          master_en,
  input logic          burst_mode,
  input logic          start_evt,
  input logic          unit_done,
  input logic          blk_step
);
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> ch_en && master_en && !end_flag && !nmi_flag && !addr_err_flag); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_wr) && $stable(bus_addr)); // R3

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_wr && bus_ack |=> bus_req && bus_wr); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> count == CW'($past(count) - 1'b1)); // R4

  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && count == CW'(1) |=> end_flag); // R5

  AST_END_ONLY_AFTER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(unit_done)); // R5

  AST_BLOCK_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    blk_step |=> bus_req && !bus_wr); // R8

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && !burst_mode |=> !bus_req); // R9
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_wr        (bus_wr),
  .bus_ack       (bus_ack),
  .bus_addr      (bus_addr),
  .count         (count),
  .end_flag      (end_flag),
  .nmi_flag      (nmi_flag),
  .addr_err_flag (addr_err_flag),
  .ch_en         (ch_en),
  .master_en     (master_en),
  .burst_mode    (burst_mode),
  .start_evt     (start_evt),
  .unit_done     (unit_done),
  .blk_step      (blk_step)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0] src_mode = 2'b01, dst_mode = 2'b01, xfer_size = 2'b00;
  logic auto_req = 1'b1, burst_mode = 1'b0, dreq = 1'b0;
  logic ch_en = 1'b0, master_en = 1'b0, int_en = 1'b0;
  logic nmi_evt = 1'b0, addr_err_evt = 1'b0;
  logic bus_req, bus_wr, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr, src_addr, dst_addr;
  logic [CW-1:0] count;
  logic end_flag, nmi_flag, addr_err_flag, end_irq, busy;

  always #4 clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW)) u_dma_chan_seq (.*);

  int n_chk = 0, n_bad = 0;
  int lat = 0, wcnt = 0, lg_n = 0;
  bit saw_gap = 1'b1;
  logic          lg_wr  [128];
  logic          lg_gap [128];
  logic [AW-1:0] lg_addr[128];

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Bus responder: acknowledges after lat idle cycles, logs each beat.
  always @(negedge clk) begin
    if (!bus_req) saw_gap = 1'b1;
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      if (wcnt >= lat) begin
        bus_ack = 1'b1;
        wcnt = 0;
        if (lg_n < 128) begin
          lg_wr[lg_n] = bus_wr;
          lg_addr[lg_n] = bus_addr;
          lg_gap[lg_n] = saw_gap;
        end
        lg_n++;
        saw_gap = 1'b0;
      end else wcnt++;
    end
  end

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input int md, input int sz);
    int st;
    st = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 16;
    if (md == 1) return a + AW'(st);
    if (md == 2) return a - AW'(st);
    return a;
  endfunction

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_count = CW'(n); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    lg_n = 0; saw_gap = 1'b1;
  endtask

  task automatic quiet();
    int q = 0;
    for (int i = 0; i < 4000 && q < 12; i++) begin
      @(negedge clk);
      if (bus_req) q = 0; else q++;
    end
  endtask

  // Expected beat log from the requirements (R3, R4, R8, R9, R10).
  task automatic check_run(input string tag, input logic [AW-1:0] s, input logic [AW-1:0] d,
                           input int units, input int sm, input int dm, input int sz, input bit brst);
    logic [AW-1:0] es = s, ed = d;
    int beats = (sz == 3) ? 4 : 1;
    int idx = 0;
    chk({tag, " R3 beat count"}, lg_n, units * beats * 2);
    for (int u = 0; u < units; u++) begin
      for (int k = 0; k < beats; k++) begin
        logic [AW-1:0] off = (sz == 3) ? AW'(4 * k) : '0;
        bit g = (u == 0 && k == 0) ? 1'b1 : (k == 0) ? !brst : 1'b0;
        if (idx + 1 < 128 && idx + 1 < lg_n) begin
          chk({tag, " R3 R8 R9 R10 read beat"}, {lg_wr[idx], lg_gap[idx], lg_addr[idx]}, {1'b0, g, es + off});
          chk({tag, " R3 R8 write beat"}, {lg_wr[idx+1], lg_gap[idx+1], lg_addr[idx+1]}, {1'b1, 1'b0, ed + off});
        end
        idx += 2;
      end
      es = nxt(es, sm, sz);
      ed = nxt(ed, dm, sz);
    end
    chk({tag, " R4 src_addr"}, src_addr, es);
    chk({tag, " R4 dst_addr"}, dst_addr, ed);
    chk({tag, " R4 count"}, count, 0);
    chk({tag, " R5 end_flag"}, end_flag, 1);
    chk({tag, " R5 end_irq"}, end_irq, int_en);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset bus_req", bus_req, 0);
    chk("reset R5 end_flag", end_flag, 0);
    chk("reset count", count, 0);
    chk("reset busy", busy, 0);
    chk("reset R5 end_irq", end_irq, 0);

    // Sweep of modes and sizes, self-request (R2, R3, R4, R5, R8, R9, R10).
    for (int sm = 0; sm < 4; sm++)
      for (int dm = 0; dm < 4; dm++)
        for (int sz = 0; sz < 4; sz++) begin
          bit b = ((sm + dm + sz) % 2) == 1;
          ch_en = 1'b0; master_en = 1'b1; auto_req = 1'b1;
          src_mode = 2'(sm); dst_mode = 2'(dm); xfer_size = 2'(sz);
          burst_mode = b; int_en = dm[0]; lat = sm % 3;
          load(16'h4000, 16'h8000, 3);
          ch_en = 1'b1;
          quiet();
          check_run("sweep R2", 16'h4000, 16'h8000, 3, sm, dm, sz, b);
          ch_en = 1'b0;
        end

    // R6: count 0 means 2^CW units.
    src_mode = 2'b01; dst_mode = 2'b01; xfer_size = 2'b00; burst_mode = 1'b1; lat = 0;
    load(16'h0100, 16'h0200, 0);
    ch_en = 1'b1;
    quiet();
    check_run("R6 zero count", 16'h0100, 16'h0200, 16, 1, 1, 0, 1'b1);

    // R1: each enable and each flag blocks a start; R12 load clears flags.
    ch_en = 1'b0;
    load(16'h0000, 16'h0040, 2);
    repeat (20) @(negedge clk);
    chk("R1 ch_en=0 holds off", lg_n, 0);
    ch_en = 1'b1; master_en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 master_en=0 holds off", lg_n, 0);
    ch_en = 1'b0; master_en = 1'b1;
    nmi_evt = 1'b1; @(negedge clk); nmi_evt = 1'b0;
    addr_err_evt = 1'b1; @(negedge clk); addr_err_evt = 1'b0;
    chk("R7 nmi flag set", nmi_flag, 1);
    chk("R7 addr err flag set", addr_err_flag, 1);
    ch_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 flags hold off", lg_n, 0);
    ch_en = 1'b0;
    load(16'h0000, 16'h0040, 2);
    chk("R12 nmi flag cleared", nmi_flag, 0);
    chk("R12 addr err flag cleared", addr_err_flag, 0);
    chk("R12 count loaded", count, 2);
    ch_en = 1'b1;
    quiet();
    chk("R12 run after load", count, 0);
    chk("R5 end after load run", end_flag, 1);
    lg_n = 0;
    repeat (20) @(negedge clk);
    chk("R1 end flag holds off", lg_n, 0);

    // External request, cycle-steal (R9, R11).
    ch_en = 1'b0; auto_req = 1'b0; burst_mode = 1'b0; xfer_size = 2'b00;
    load(16'h1000, 16'h2000, 3);
    ch_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 no edge no start", lg_n, 0);
    dreq = 1'b1;
    repeat (30) @(negedge clk);
    quiet();
    chk("R11 held dreq one unit", count, 2);
    dreq = 1'b0; repeat (3) @(negedge clk); dreq = 1'b1;
    quiet();
    chk("R9 fresh edge one unit", count, 1);
    ch_en = 1'b0; dreq = 1'b0; repeat (3) @(negedge clk); dreq = 1'b1;
    repeat (10) @(negedge clk);
    chk("R11 pending while disabled", lg_n, 4);
    ch_en = 1'b1;
    quiet();
    chk("R11 pending edge starts", count, 0);
    chk("R11 pending edge end flag", end_flag, 1);
    dreq = 1'b0;

    // External edge, burst: one edge runs the whole count (R10).
    ch_en = 1'b0; burst_mode = 1'b1; lat = 1;
    load(16'h1000, 16'h2000, 3);
    ch_en = 1'b1;
    repeat (5) @(negedge clk);
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    quiet();
    check_run("R10 edge burst", 16'h1000, 16'h2000, 3, 1, 1, 0, 1'b1);

    // Aborts mid-run (R7).
    ch_en = 1'b0; auto_req = 1'b1; lat = 3;
    load(16'h3000, 16'h5000, 10);
    ch_en = 1'b1;
    wait (lg_n >= 1);
    @(negedge clk); nmi_evt = 1'b1; @(negedge clk); nmi_evt = 1'b0;
    quiet();
    chk("R7 nmi abort count", count, 9);
    chk("R7 nmi abort no end", end_flag, 0);
    chk("R7 nmi abort beats", lg_n, 2);
    chk("R7 nmi abort src", src_addr, 16'h3001);

    ch_en = 1'b0;
    load(16'h3000, 16'h5000, 10);
    ch_en = 1'b1;
    wait (lg_n >= 1);
    @(negedge clk); ch_en = 1'b0;
    quiet();
    chk("R7 disable abort count", count, 9);
    chk("R7 disable abort no end", end_flag, 0);

    // Abort inside a 16-byte block (R8).
    xfer_size = 2'b11;
    load(16'h6000, 16'h7000, 3);
    ch_en = 1'b1;
    wait (lg_n >= 1);
    @(negedge clk); addr_err_evt = 1'b1; @(negedge clk); addr_err_evt = 1'b0;
    quiet();
    chk("R8 block finished beats", lg_n, 8);
    chk("R8 block count", count, 2);
    chk("R8 block src", src_addr, 16'h6010);
    chk("R7 addr err flag", addr_err_flag, 1);
    chk("R8 no end", end_flag, 0);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule